// File: doc/BRIEF.md
# Register Dependence Interlock Unit

This unit guards a five-stage integer pipeline (fetch, decode, execute, memory, writeback) that has no forwarding network. It looks at the instruction sitting in decode and works out which register it will write and which of its two source fields it actually reads, based on the instruction class. It also carries, for the three stages downstream of decode, the destination register and write flag of each instruction in flight, advancing them once per clock.

When a source that the decode instruction really reads names a register that a write-enabled instruction in execute, memory or writeback is about to produce, the unit raises `stall`. The surrounding pipeline uses `stall` to keep fetch and decode frozen; inside the unit, the execute slot is loaded with an empty entry (a bubble) instead of the decoded instruction. Because the register file offers no same-cycle write-then-read path, a producer in writeback still blocks its consumer, so an immediately dependent instruction waits three cycles. Register 0 and instructions that write nothing never cause a wait.

Top module: `hz_interlock`

## Requirements
- R1: While `rst` is high on a clock edge, all three stage write flags clear to 0 and the stage destinations to 0; with a nop in decode, `stall` is then 0.
- R2: A write-enabled instruction presents its destination on `ex_dest` one cycle after it leaves decode: class ALU (code 1) uses `id_rd`, class ALUI (2) and LOAD (3) use `id_rt`, JAL (7) and JALR (9) use register 31; any entry whose write flag is 0 shows destination 0.
- R3: The write flag is 1 for ALU, ALUI and LOAD only when the selected destination is nonzero, always 1 for JAL and JALR, and 0 for NOP (0), STORE (4), BRZ (5), JMP (6) and JR (8).
- R4: The `id_rs` field is compared only for ALU, ALUI, LOAD, STORE, BRZ, JR and JALR; for JMP, JAL and NOP it causes no stall.
- R5: The `id_rt` field is compared only for ALU and STORE; for every other class it causes no stall.
- R6: `stall` is 1 exactly when an enabled source field equals the destination of a write-enabled entry in execute, memory or writeback.
- R7: On a stalled cycle the next execute entry is a bubble (write flag 0, destination 0), while the memory and writeback entries keep advancing from execute and memory.
- R8: A consumer directly behind its producer sees exactly three stall cycles; with one or two independent instructions between them it sees two or one.
- R9: A producer that has reached writeback still stalls a matching consumer in decode.
- R10: Register 0 never causes a stall, whichever class produces or reads it.
- R11: Opcode codes 10 to 15 neither write nor read any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_op | input | 4 | Class code of the decode-stage instruction |
| id_rs | input | AW | First source field of the decode instruction |
| id_rt | input | AW | Second source / immediate-class destination field |
| id_rd | input | AW | Register-register destination field |
| stall | output | 1 | Hold fetch and decode, insert bubble into execute |
| ex_dest | output | AW | Destination held for the execute stage |
| ex_we | output | 1 | Write flag held for the execute stage |
| mem_dest | output | AW | Destination held for the memory stage |
| mem_we | output | 1 | Write flag held for the memory stage |
| wb_dest | output | AW | Destination held for the writeback stage |
| wb_we | output | 1 | Write flag held for the writeback stage |

## Verification
The bench sweeps producer-to-consumer distance from zero to three gaps on both source fields; a unit that forgot the writeback comparison would let the two-gap consumer through with no wait, and one that failed to inject a bubble would stall forever on the same entry. Every class is tried as a reader with a matching producer, so a unit that compared `id_rt` for immediate or load instructions would stall where it must not, and one that ignored `id_rs` for jump-register would run ahead of its producer. Writes to register 0, the link destination of JAL, and the unused codes are issued as producers; a unit that let register 0 carry a write flag or treated unused codes as writers would show a spurious stall.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OPC_NOP   = 4'd0;
  localparam logic [OPW-1:0] OPC_ALU   = 4'd1;
  localparam logic [OPW-1:0] OPC_ALUI  = 4'd2;
  localparam logic [OPW-1:0] OPC_LOAD  = 4'd3;
  localparam logic [OPW-1:0] OPC_STORE = 4'd4;
  localparam logic [OPW-1:0] OPC_BRZ   = 4'd5;
  localparam logic [OPW-1:0] OPC_JMP   = 4'd6;
  localparam logic [OPW-1:0] OPC_JAL   = 4'd7;
  localparam logic [OPW-1:0] OPC_JR    = 4'd8;
  localparam logic [OPW-1:0] OPC_JALR  = 4'd9;

  typedef enum logic [1:0] {
    DSEL_NONE,
    DSEL_RD,
    DSEL_RT,
    DSEL_LINK
  } dsel_e;
endpackage

// File: rtl/hz_decode.sv
module hz_decode
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [OPW-1:0] op,
  input  logic [AW-1:0]  rt,
  input  logic [AW-1:0]  rd,
  output logic [AW-1:0]  dest,
  output logic           we,
  output logic           re_rs,
  output logic           re_rt
);
  localparam logic [AW-1:0] LINK = {AW{1'b1}};

  dsel_e          sel;
  logic [AW-1:0]  pick;

  always_comb begin
    sel   = DSEL_NONE;
    re_rs = 1'b0;
    re_rt = 1'b0;
    case (op)
      OPC_ALU:   begin sel = DSEL_RD;   re_rs = 1'b1; re_rt = 1'b1; end
      OPC_ALUI:  begin sel = DSEL_RT;   re_rs = 1'b1; end
      OPC_LOAD:  begin sel = DSEL_RT;   re_rs = 1'b1; end
      OPC_STORE: begin                  re_rs = 1'b1; re_rt = 1'b1; end
      OPC_BRZ:   begin                  re_rs = 1'b1; end
      OPC_JR:    begin                  re_rs = 1'b1; end
      OPC_JAL:   begin sel = DSEL_LINK; end
      OPC_JALR:  begin sel = DSEL_LINK; re_rs = 1'b1; end
      default:   begin sel = DSEL_NONE; end
    endcase
  end

  always_comb begin
    case (sel)
      DSEL_RD:   pick = rd;
      DSEL_RT:   pick = rt;
      DSEL_LINK: pick = LINK;
      default:   pick = '0;
    endcase
    we   = (sel == DSEL_LINK) || ((sel != DSEL_NONE) && (pick != '0));
    dest = we ? pick : '0;
  end
endmodule

// File: rtl/hz_stage_pipe.sv
module hz_stage_pipe #(
  parameter int AW   = 5,
  parameter int NSTG = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bubble,
  input  logic [AW-1:0]            in_dest,
  input  logic                     in_we,
  output logic [NSTG-1:0][AW-1:0]  st_dest,
  output logic [NSTG-1:0]          st_we
);
  genvar s;
  generate
    for (s = 0; s < NSTG; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst || bubble) begin
            st_dest[s] <= '0;
            st_we[s]   <= 1'b0;
          end else begin
            st_dest[s] <= in_dest;
            st_we[s]   <= in_we;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) begin
            st_dest[s] <= '0;
            st_we[s]   <= 1'b0;
          end else begin
            st_dest[s] <= st_dest[s-1];
            st_we[s]   <= st_we[s-1];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/hz_match.sv
module hz_match #(
  parameter int AW   = 5,
  parameter int NSTG = 3
) (
  input  logic [AW-1:0]            rs,
  input  logic [AW-1:0]            rt,
  input  logic                     re_rs,
  input  logic                     re_rt,
  input  logic [NSTG-1:0][AW-1:0]  st_dest,
  input  logic [NSTG-1:0]          st_we,
  output logic                     hit
);
  logic [NSTG-1:0] hit_rs;
  logic [NSTG-1:0] hit_rt;

  genvar s;
  generate
    for (s = 0; s < NSTG; s++) begin : g_cmp
      assign hit_rs[s] = st_we[s] && (st_dest[s] == rs);
      assign hit_rt[s] = st_we[s] && (st_dest[s] == rt);
    end
  endgenerate

  assign hit = (re_rs && (|hit_rs)) || (re_rt && (|hit_rt));
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] id_op,
  input  logic [AW-1:0]  id_rs,
  input  logic [AW-1:0]  id_rt,
  input  logic [AW-1:0]  id_rd,
  output logic           stall,
  output logic [AW-1:0]  ex_dest,
  output logic           ex_we,
  output logic [AW-1:0]  mem_dest,
  output logic           mem_we,
  output logic [AW-1:0]  wb_dest,
  output logic           wb_we
);
  localparam int NSTG = 3;

  logic [AW-1:0]           dec_dest;
  logic                    dec_we;
  logic                    dec_re_rs;
  logic                    dec_re_rt;
  logic [NSTG-1:0][AW-1:0] st_dest;
  logic [NSTG-1:0]         st_we;

  hz_decode #(.AW(AW)) u_dec (
    .op    (id_op),
    .rt    (id_rt),
    .rd    (id_rd),
    .dest  (dec_dest),
    .we    (dec_we),
    .re_rs (dec_re_rs),
    .re_rt (dec_re_rt)
  );

  hz_match #(.AW(AW), .NSTG(NSTG)) u_match (
    .rs      (id_rs),
    .rt      (id_rt),
    .re_rs   (dec_re_rs),
    .re_rt   (dec_re_rt),
    .st_dest (st_dest),
    .st_we   (st_we),
    .hit     (stall)
  );

  hz_stage_pipe #(.AW(AW), .NSTG(NSTG)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .bubble  (stall),
    .in_dest (dec_dest),
    .in_we   (dec_we),
    .st_dest (st_dest),
    .st_we   (st_we)
  );

  assign ex_dest  = st_dest[0];
  assign ex_we    = st_we[0];
  assign mem_dest = st_dest[1];
  assign mem_we   = st_we[1];
  assign wb_dest  = st_dest[2];
  assign wb_we    = st_we[2];
endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic [OPW-1:0] id_op,
  input logic [AW-1:0]  id_rs,
  input logic [AW-1:0]  id_rt,
  input logic           stall,
  input logic [AW-1:0]  ex_dest,
  input logic           ex_we,
  input logic [AW-1:0]  mem_dest,
  input logic           mem_we,
  input logic [AW-1:0]  wb_dest,
  input logic           wb_we
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ex_we && !mem_we && !wb_we));

  p_idle_dest_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !ex_we |-> (ex_dest == '0));

  p_link_dest_r2: assert property (@(posedge clk) disable iff (rst)
    (id_op == OPC_JAL && !stall) |=> (ex_we && ex_dest == {AW{1'b1}}));

  p_stall_cause_r6: assert property (@(posedge clk) disable iff (rst)
    stall |-> ((ex_we  && (ex_dest  == id_rs || ex_dest  == id_rt)) ||
               (mem_we && (mem_dest == id_rs || mem_dest == id_rt)) ||
               (wb_we  && (wb_dest  == id_rs || wb_dest  == id_rt))));

  p_bubble_r7: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!ex_we && ex_dest == '0));

  p_mem_follows_r7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (mem_we == $past(ex_we) && mem_dest == $past(ex_dest)));

  p_wb_follows_r7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (wb_we == $past(mem_we) && wb_dest == $past(mem_dest)));

  p_no_reg0_write_r10: assert property (@(posedge clk) disable iff (rst)
    (ex_we || mem_we || wb_we) |->
      ((!ex_we || ex_dest != '0) && (!mem_we || mem_dest != '0) && (!wb_we || wb_dest != '0)));
endmodule

bind hz_interlock hz_interlock_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .id_op    (id_op),
  .id_rs    (id_rs),
  .id_rt    (id_rt),
  .stall    (stall),
  .ex_dest  (ex_dest),
  .ex_we    (ex_we),
  .mem_dest (mem_dest),
  .mem_we   (mem_we),
  .wb_dest  (wb_dest),
  .wb_we    (wb_we)
);

// File: tb/hz_interlock_test.sv
`timescale 1ns/1ps
module hz_interlock_test;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    id_op = 4'd0;
  logic [AW-1:0] id_rs = '0;
  logic [AW-1:0] id_rt = '0;
  logic [AW-1:0] id_rd = '0;
  logic          stall;
  logic [AW-1:0] ex_dest, mem_dest, wb_dest;
  logic          ex_we, mem_we, wb_we;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // bench-side model of the three downstream entries
  logic [AW-1:0] m_d [3];
  logic          m_w [3];

  always #10 clk = ~clk;

  hz_interlock #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .id_op(id_op), .id_rs(id_rs), .id_rt(id_rt), .id_rd(id_rd),
    .stall(stall), .ex_dest(ex_dest), .ex_we(ex_we), .mem_dest(mem_dest),
    .mem_we(mem_we), .wb_dest(wb_dest), .wb_we(wb_we)
  );

  // class codes: 0 nop,1 alu,2 alui,3 load,4 store,5 brz,6 jmp,7 jal,8 jr,9 jalr
  function automatic logic [AW-1:0] ref_pick(input logic [3:0] op, input logic [AW-1:0] rt,
                                             input logic [AW-1:0] rd);
    case (op)
      4'd1:       return rd;
      4'd2, 4'd3: return rt;
      4'd7, 4'd9: return 5'd31;
      default:    return '0;
    endcase
  endfunction

  function automatic logic ref_we(input logic [3:0] op, input logic [AW-1:0] rt,
                                  input logic [AW-1:0] rd);
    if (op == 4'd7 || op == 4'd9) return 1'b1;
    if (op == 4'd1 || op == 4'd2 || op == 4'd3) return ref_pick(op, rt, rd) != '0;
    return 1'b0;
  endfunction

  function automatic logic ref_rs_on(input logic [3:0] op);
    return op inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd8, 4'd9};
  endfunction

  function automatic logic ref_rt_on(input logic [3:0] op);
    return op inside {4'd1, 4'd4};
  endfunction

  function automatic logic ref_stall();
    logic s = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (m_w[k] && ref_rs_on(id_op) && m_d[k] == id_rs) s = 1'b1;
      if (m_w[k] && ref_rt_on(id_op) && m_d[k] == id_rt) s = 1'b1;
    end
    return s;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: compare at the falling edge, then advance the model at the rising edge
  task automatic step(input string tag, output bit st);
    @(negedge clk);
    st = ref_stall();
    check(tag, "stall", int'(stall), int'(st));
    check(tag, "ex_we", int'(ex_we), int'(m_w[0]));
    check(tag, "ex_dest", int'(ex_dest), int'(m_d[0]));
    check(tag, "mem_we", int'(mem_we), int'(m_w[1]));
    check(tag, "mem_dest", int'(mem_dest), int'(m_d[1]));
    check(tag, "wb_we", int'(wb_we), int'(m_w[2]));
    check(tag, "wb_dest", int'(wb_dest), int'(m_d[2]));
    @(posedge clk);
    m_w[2] = m_w[1]; m_d[2] = m_d[1];
    m_w[1] = m_w[0]; m_d[1] = m_d[0];
    if (st) begin
      m_w[0] = 1'b0; m_d[0] = '0;
    end else begin
      m_w[0] = ref_we(id_op, id_rt, id_rd);
      m_d[0] = m_w[0] ? ref_pick(id_op, id_rt, id_rd) : '0;
    end
    #1;
  endtask

  // present an instruction in decode and hold it until it moves on
  task automatic issue(input logic [3:0] op, input logic [AW-1:0] rs, input logic [AW-1:0] rt,
                       input logic [AW-1:0] rd, input string tag, output int nst);
    bit st;
    id_op = op; id_rs = rs; id_rt = rt; id_rd = rd;
    nst = 0;
    do begin
      step(tag, st);
      if (st) nst++;
    end while (st && nst < 10);
  endtask

  task automatic drain(input string tag);
    int n;
    for (int k = 0; k < 3; k++) issue(4'd0, '0, '0, '0, tag, n);
  endtask

  task automatic t_reset();
    rst = 1'b1; id_op = 4'd0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int k = 0; k < 3; k++) begin m_w[k] = 1'b0; m_d[k] = '0; end
    @(negedge clk);
    check("R1", "stall", int'(stall), 0);
    check("R1", "ex_we", int'(ex_we), 0);
    check("R1", "mem_we", int'(mem_we), 0);
    check("R1", "wb_we", int'(wb_we), 0);
    check("R1", "wb_dest", int'(wb_dest), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_dest_select();
    int n;
    issue(4'd1, 5'd0, 5'd0, 5'd5,  "R2", n);
    issue(4'd2, 5'd0, 5'd6, 5'd11, "R2", n);
    issue(4'd3, 5'd0, 5'd7, 5'd12, "R2", n);
    issue(4'd7, 5'd0, 5'd8, 5'd13, "R2", n);
    issue(4'd9, 5'd0, 5'd0, 5'd14, "R2", n);
    drain("R2");
    check("R2", "dest-select stalls", n, 0);
  endtask

  task automatic t_we_rules();
    int n;
    issue(4'd1, 5'd0, 5'd3, 5'd0, "R3", n);
    issue(4'd2, 5'd0, 5'd0, 5'd4, "R3", n);
    issue(4'd4, 5'd0, 5'd0, 5'd4, "R3", n);
    issue(4'd5, 5'd0, 5'd0, 5'd4, "R3", n);
    issue(4'd6, 5'd0, 5'd9, 5'd4, "R3", n);
    issue(4'd8, 5'd0, 5'd9, 5'd4, "R3", n);
    issue(4'd0, 5'd0, 5'd9, 5'd4, "R3", n);
    drain("R3");
  endtask

  task automatic t_rs_classes();
    int n;
    for (int op = 0; op < 10; op++) begin
      issue(4'd1, 5'd0, 5'd0, 5'd9, "R4", n);
      issue(4'(op), 5'd9, 5'd0, 5'd0, "R4", n);
      check("R4", $sformatf("rs stalls class %0d", op), n,
            ref_rs_on(4'(op)) ? 3 : 0);
      drain("R4");
    end
  endtask

  task automatic t_rt_classes();
    int n;
    for (int op = 0; op < 10; op++) begin
      issue(4'd2, 5'd0, 5'd9, 5'd0, "R5", n);
      issue(4'(op), 5'd0, 5'd9, 5'd17, "R5", n);
      check("R5", $sformatf("rt stalls class %0d", op), n,
            (op == 1 || op == 4) ? 3 : 0);
      drain("R5");
    end
  endtask

  task automatic t_distance();
    int n;
    string tg;
    for (int side = 0; side < 2; side++) begin
      for (int gap = 0; gap < 4; gap++) begin
        tg = (gap == 0) ? "R8" : (gap == 2) ? "R9" : "R6";
        issue(4'd3, 5'd0, 5'd12, 5'd0, tg, n);
        for (int k = 0; k < gap; k++) issue(4'd0, 5'd0, 5'd0, 5'd0, tg, n);
        if (side == 0) issue(4'd1, 5'd12, 5'd0, 5'd20, tg, n);
        else           issue(4'd4, 5'd0, 5'd12, 5'd0, tg, n);
        check(tg, $sformatf("stalls gap %0d side %0d", gap, side), n, 3 - gap);
        drain(tg);
      end
    end
  endtask

  task automatic t_bubble();
    int n;
    issue(4'd7, 5'd0, 5'd0, 5'd0, "R7", n);
    issue(4'd8, 5'd31, 5'd0, 5'd0, "R7", n);
    check("R7", "link consumer stalls", n, 3);
    issue(4'd1, 5'd31, 5'd0, 5'd22, "R7", n);
    check("R7", "after bubbles", n, 0);
    drain("R7");
  endtask

  task automatic t_zero_reg();
    int n;
    issue(4'd1, 5'd0, 5'd0, 5'd0, "R10", n);
    issue(4'd3, 5'd0, 5'd0, 5'd0, "R10", n);
    issue(4'd1, 5'd0, 5'd0, 5'd3, "R10", n);
    check("R10", "reg0 reader", n, 0);
    issue(4'd4, 5'd0, 5'd0, 5'd0, "R10", n);
    check("R10", "reg0 store", n, 0);
    drain("R10");
  endtask

  task automatic t_unused();
    int n;
    for (int op = 10; op < 16; op++) begin
      issue(4'd1, 5'd0, 5'd0, 5'd9, "R11", n);
      issue(4'(op), 5'd9, 5'd9, 5'd9, "R11", n);
      check("R11", $sformatf("unused %0d as reader", op), n, 0);
      issue(4'd1, 5'd9, 5'd9, 5'd1, "R11", n);
      drain("R11");
      issue(4'(op), 5'd0, 5'd9, 5'd9, "R11", n);
      issue(4'd1, 5'd9, 5'd9, 5'd2, "R11", n);
      check("R11", $sformatf("unused %0d as writer", op), n, 0);
      drain("R11");
    end
  endtask

  initial begin
    t_reset();
    t_dest_select();
    t_we_rules();
    t_rs_classes();
    t_rt_classes();
    t_distance();
    t_bubble();
    t_zero_reg();
    t_unused();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog all: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule